// File: doc/BRIEF.md
# Key Matrix Column Scanner

This block finds which key of a 4x4 active-high key matrix is pressed. It drives one column line high at a time and looks at the four row lines. Each row line is low when idle and goes high when a key in the driven column closes. The controller has a scanning state for every column and a holding state for every row of every column, which gives 4 + 16 states in all.

With no key down, the controller steps through the columns in a loop. When a row is seen high, it enters the holding state for that column and row. It keeps that column driven and reports the key. When the held key is let go while another key in the same column is still down, it moves straight to that key's holding state. A press on top of a held key in the same column is therefore not lost, and several keys held together never stall the scan.

The controller advances only on a slow scan enable, typically about 183 Hz taken from a fast system clock. The row inputs are first passed through a configurable synchronizer. The key code and the key-down flag feed a debouncer further down the chain.

Top module: `kpd_matrix_scanner`

## Requirements
- R1: Synchronous reset (rst_n low at a rising clock edge) places the controller in the scanning state of column 0: col_drive = 4'b0001, key_down = 0, key_code = 8'h00.
- R2: col_drive has exactly one bit high in every cycle after reset, and bit c means column c is driven.
- R3: In a scanning state, an enabled clock edge with no synchronized row high moves the drive to the next column, and column 3 wraps to column 0.
- R4: At a clock edge with scan_en low, col_drive, key_code and key_down keep their values whatever the rows do.
- R5: In a scanning state, an enabled edge that sees any synchronized row high enters the holding state for that column. key_down goes to 1, col_drive stays on the column, and key_code becomes {row one-hot in bits 7:4, column one-hot in bits 3:0}.
- R6: In a holding state, while the held row stays high, the controller stays in that state. This holds even if other rows of the column also go high.
- R7: When several rows are high together and a new holding state is chosen, the lowest-numbered row wins.
- R8: When the held row drops while another row of the same column is high, the next enabled edge enters that row's holding state. key_down stays 1 and key_code changes to the new key.
- R9: When the held row drops and no row of the column is high, the next enabled edge goes to the scanning state of the next column and key_down falls. key_code keeps its last value until another key is held.
- R10: row_in passes through SYNC_STAGES (default 2) flops before the controller uses it. With the default, a row that rises one clock before an enabled edge is not yet seen at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| scan_en | input | 1 | One-cycle step enable for the controller (slow scan rate) |
| row_in | input | NUM_ROWS | Row sense lines, active high |
| col_drive | output | NUM_COLS | One-hot column drive |
| key_code | output | NUM_ROWS+NUM_COLS | {row one-hot, column one-hot} of the last held key |
| key_down | output | 1 | High while in a holding state |

## Verification
Some properties are checked on every cycle. The column drive must stay one-hot. All outputs must be frozen when the enable is low. The column must rotate by one on each enabled step of a key-free scan. The column half of the key code must match the driven column while a key is held, and the row half must then be one-hot. The column must not move during a hold, and the code must not change as the hold ends.

Other behaviour only the bench scenarios can show, because it depends on which keys are modelled as pressed. This covers the choice of the lowest row, the hand-over from one key to another in the same column, the rule that keys in undriven columns are ignored, and the one-clock blind spot that the synchronizer creates.

// File: rtl/kpd_pkg.sv
// Package: shared types for the key matrix scanner.
// Assumes: nothing beyond IEEE 1800-2017.
package kpd_pkg;

    // Controller mode: stepping through columns, or parked on a held key
    typedef enum logic {
        MODE_SCAN = 1'b0,
        MODE_HOLD = 1'b1
    } kpd_mode_e;

endpackage

// File: rtl/kpd_row_sync.sv
// Module: kpd_row_sync
// Passes the asynchronous row lines through STAGES flops before use.
// Assumes: STAGES >= 0; a value of 0 selects a direct feed-through.
module kpd_row_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    generate
        if (STAGES == 0) begin : g_bypass
            // Feed-through variant: no synchronizing flops
            assign d_out = d_in;
        end else begin : g_chain
            logic [WIDTH-1:0] stage_q [STAGES];

            // First flop captures the raw lines
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[0] <= '0;
                else        stage_q[0] <= d_in;
            end

            for (genvar s = 1; s < STAGES; s++) begin : g_stage
                // Each later flop takes the previous stage
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end

            assign d_out = stage_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/kpd_scan_fsm.sv
// Module: kpd_scan_fsm
// Column/row state machine. The state is (mode, column, row): one scanning
// state per column plus one holding state per row of each column.
// Assumes: NUM_COLS >= 2, NUM_ROWS >= 2; rows_s already synchronized;
// the machine moves only on clock edges where step_en is high.
module kpd_scan_fsm
    import kpd_pkg::*;
#(
    parameter int NUM_COLS = 4,
    parameter int NUM_ROWS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step_en,
    input  logic [NUM_ROWS-1:0] rows_s,
    output logic [NUM_COLS-1:0] col_oh,
    output logic                holding,
    output logic                load_code,
    output logic [NUM_ROWS-1:0] nxt_row_oh,
    output logic [NUM_COLS-1:0] nxt_col_oh
);

    localparam int COL_W = $clog2(NUM_COLS);
    localparam int ROW_W = $clog2(NUM_ROWS);
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(NUM_COLS - 1);

    kpd_mode_e        mode_q, mode_d;
    logic [COL_W-1:0] col_q, col_d;
    logic [ROW_W-1:0] row_q, row_d;
    logic [ROW_W-1:0] low_row;
    logic [COL_W-1:0] next_col;
    logic             any_row;

    // Lowest-numbered high row wins when a new row is chosen
    always_comb begin
        low_row = '0;
        for (int i = NUM_ROWS - 1; i >= 0; i--) begin
            if (rows_s[i]) low_row = ROW_W'(i);
        end
    end

    assign any_row  = |rows_s;
    assign next_col = (col_q == LAST_COL) ? '0 : col_q + COL_W'(1);

    // Next-state choice: keep the held row, pass to another row, or move on
    always_comb begin
        mode_d = mode_q;
        col_d  = col_q;
        row_d  = row_q;
        if (step_en) begin
            if (mode_q == MODE_HOLD && rows_s[row_q]) begin
                mode_d = MODE_HOLD;
            end else if (any_row) begin
                mode_d = MODE_HOLD;
                row_d  = low_row;
            end else begin
                mode_d = MODE_SCAN;
                col_d  = next_col;
            end
        end
    end

    // State register with synchronous reset to column 0 scanning
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_SCAN;
            col_q  <= '0;
            row_q  <= '0;
        end else begin
            mode_q <= mode_d;
            col_q  <= col_d;
            row_q  <= row_d;
        end
    end

    // One-hot decode of present column and of next row/column
    always_comb begin
        col_oh                = '0;
        col_oh[col_q]         = 1'b1;
        nxt_col_oh            = '0;
        nxt_col_oh[col_d]     = 1'b1;
        nxt_row_oh            = '0;
        nxt_row_oh[row_d]     = 1'b1;
    end

    assign holding   = (mode_q == MODE_HOLD);
    assign load_code = step_en && (mode_d == MODE_HOLD);

endmodule

// File: rtl/kpd_code_reg.sv
// Module: kpd_code_reg
// Holds the key code {row one-hot, column one-hot} of the latest held key.
// Assumes: load is high only on edges where the controller enters or
// stays in a holding state; the value is kept at all other times.
module kpd_code_reg #(
    parameter int NUM_COLS = 4,
    parameter int NUM_ROWS = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load,
    input  logic [NUM_ROWS-1:0]          row_oh,
    input  logic [NUM_COLS-1:0]          col_oh,
    output logic [NUM_ROWS+NUM_COLS-1:0] code
);

    // Capture the next held key, else keep the last one
    always_ff @(posedge clk) begin
        if (!rst_n)    code <= '0;
        else if (load) code <= {row_oh, col_oh};
    end

endmodule

// File: rtl/kpd_matrix_scanner.sv
// Module: kpd_matrix_scanner (top)
// Scans an active-high key matrix one column at a time and reports the
// held key as a one-hot code plus a key-down flag for a debouncer.
// Assumes: scan_en is a single-cycle pulse at the scan rate, spaced at
// least SYNC_STAGES+1 clocks apart so rows settle after a column change.
module kpd_matrix_scanner #(
    parameter int NUM_COLS    = 4,
    parameter int NUM_ROWS    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         scan_en,
    input  logic [NUM_ROWS-1:0]          row_in,
    output logic [NUM_COLS-1:0]          col_drive,
    output logic [NUM_ROWS+NUM_COLS-1:0] key_code,
    output logic                         key_down
);

    logic [NUM_ROWS-1:0] rows_s;
    logic                load_code;
    logic [NUM_ROWS-1:0] nxt_row_oh;
    logic [NUM_COLS-1:0] nxt_col_oh;

    kpd_row_sync #(
        .WIDTH (NUM_ROWS),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_in (row_in),
        .d_out(rows_s)
    );

    kpd_scan_fsm #(
        .NUM_COLS(NUM_COLS),
        .NUM_ROWS(NUM_ROWS)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_en   (scan_en),
        .rows_s    (rows_s),
        .col_oh    (col_drive),
        .holding   (key_down),
        .load_code (load_code),
        .nxt_row_oh(nxt_row_oh),
        .nxt_col_oh(nxt_col_oh)
    );

    kpd_code_reg #(
        .NUM_COLS(NUM_COLS),
        .NUM_ROWS(NUM_ROWS)
    ) u_code (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_code),
        .row_oh(nxt_row_oh),
        .col_oh(nxt_col_oh),
        .code  (key_code)
    );

endmodule

// File: rtl/kpd_scanner_chk.sv
// Module: kpd_scanner_chk
// Cycle-by-cycle properties of the scanner's ports, bound to the top.
// Assumes: rst_n is low from time zero for at least two clock edges.
module kpd_scanner_chk #(
    parameter int NUM_COLS = 4,
    parameter int NUM_ROWS = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         scan_en,
    input logic [NUM_COLS-1:0]          col_drive,
    input logic [NUM_ROWS+NUM_COLS-1:0] key_code,
    input logic                         key_down
);

    // R2
    col_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(col_drive) == 1);

    // R4
    idle_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(scan_en)) |->
            ($stable(col_drive) && $stable(key_code) && $stable(key_down)));

    // R3
    col_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(scan_en) && !$past(key_down) && !key_down) |->
            (col_drive == {$past(col_drive[NUM_COLS-2:0]), $past(col_drive[NUM_COLS-1])}));

    // R5
    code_col_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_down |-> (key_code[NUM_COLS-1:0] == col_drive));

    // R5
    code_row_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_down |-> ($countones(key_code[NUM_ROWS+NUM_COLS-1:NUM_COLS]) == 1));

    // R6
    hold_col_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(key_down) && key_down) |-> $stable(col_drive));

    // R9
    release_code_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(key_down)) |-> $stable(key_code));

endmodule

bind kpd_matrix_scanner kpd_scanner_chk #(
    .NUM_COLS(NUM_COLS),
    .NUM_ROWS(NUM_ROWS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scan_en  (scan_en),
    .col_drive(col_drive),
    .key_code (key_code),
    .key_down (key_down)
);

// File: tb/tb_kpd_matrix_scanner.sv
// Bench: models a 4x4 key matrix around the scanner and checks its ports.
module tb_kpd_matrix_scanner;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scan_en = 1'b0;
    logic [3:0] row_in;
    logic [3:0] col_drive;
    logic [7:0] key_code;
    logic       key_down;

    logic [15:0] keys = '0;       // bit c*4+r = key at column c, row r
    logic        ovr_en = 1'b0;
    logic [3:0]  ovr_rows = '0;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    kpd_matrix_scanner dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scan_en  (scan_en),
        .row_in   (row_in),
        .col_drive(col_drive),
        .key_code (key_code),
        .key_down (key_down)
    );

    // Matrix model: rows of the driven column show the pressed keys
    always_comb begin
        row_in = '0;
        for (int c = 0; c < 4; c++)
            if (col_drive[c]) row_in = row_in | keys[c*4 +: 4];
        if (ovr_en) row_in = ovr_rows;
    end

    task automatic check(input string req, input logic [3:0] ec,
                         input logic ek, input logic [7:0] eco);
        checks++;
        if (col_drive !== ec || key_down !== ek || key_code !== eco) begin
            errors++;
            $display("FAIL %s: actual col=%b down=%b code=%h expected col=%b down=%b code=%h",
                     req, col_drive, key_down, key_code, ec, ek, eco);
        end
    endtask

    // One enabled step after the rows have settled through the synchronizer
    task automatic step();
        repeat (3) @(negedge clk);
        scan_en = 1'b1;
        @(negedge clk);
        scan_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // {keys, expected col, expected key_down, expected code}
    localparam logic [28:0] VEC [20] = '{
        {16'h0000, 4'b0010, 1'b0, 8'h00},  // R3 step to col1
        {16'h0000, 4'b0100, 1'b0, 8'h00},  // R3
        {16'h0000, 4'b1000, 1'b0, 8'h00},  // R3
        {16'h0000, 4'b0001, 1'b0, 8'h00},  // R3 wrap
        {16'h0040, 4'b0010, 1'b0, 8'h00},  // key in col1 unseen at col0
        {16'h0040, 4'b0010, 1'b1, 8'h42},  // R5 hold col1 row2
        {16'h0040, 4'b0010, 1'b1, 8'h42},  // R6 stay
        {16'h0050, 4'b0010, 1'b1, 8'h42},  // R6 lower row added, stay
        {16'h0010, 4'b0010, 1'b1, 8'h12},  // R8 hand over to row0
        {16'h0000, 4'b0100, 1'b0, 8'h12},  // R9 release, code kept
        {16'h0000, 4'b1000, 1'b0, 8'h12},  // R9
        {16'h000A, 4'b0001, 1'b0, 8'h12},  // R3 wrap
        {16'h000A, 4'b0001, 1'b1, 8'h21},  // R7 lowest of rows 1,3
        {16'h0008, 4'b0001, 1'b1, 8'h81},  // R8 hand over to row3
        {16'h0108, 4'b0001, 1'b1, 8'h81},  // R6 other column ignored
        {16'h0000, 4'b0010, 1'b0, 8'h81},  // R9
        {16'h8000, 4'b0100, 1'b0, 8'h81},  // R3
        {16'h8000, 4'b1000, 1'b0, 8'h81},  // R3
        {16'h8000, 4'b1000, 1'b1, 8'h88},  // R5 hold col3 row3
        {16'h0000, 4'b0001, 1'b0, 8'h88}   // R9 wrap from hold
    };

    initial begin
        do_reset();
        @(negedge clk);
        check("R1 reset", 4'b0001, 1'b0, 8'h00);

        foreach (VEC[i]) begin
            keys = VEC[i][28:13];
            step();
            check($sformatf("R3/R5-R9 vector %0d", i), VEC[i][12:9], VEC[i][8], VEC[i][7:0]);
        end

        // R1: reset from a holding state
        keys = 16'h0001;
        step();
        check("R5 hold col0 row0", 4'b0001, 1'b1, 8'h11);
        do_reset();
        @(negedge clk);
        check("R1 reset from hold", 4'b0001, 1'b0, 8'h00);

        // R4: key present but no enable for many cycles
        keys = 16'h0001;
        repeat (20) @(negedge clk);
        check("R4 no enable", 4'b0001, 1'b0, 8'h00);
        keys = 16'h0000;

        // R10: row rising one clock before the enabled edge is not yet seen
        do_reset();
        @(negedge clk);
        ovr_en = 1'b1;
        ovr_rows = 4'b0001;
        scan_en = 1'b1;
        @(negedge clk);
        scan_en = 1'b0;
        check("R10 unsynced row ignored", 4'b0010, 1'b0, 8'h00);
        step();
        check("R10 synced row seen", 4'b0010, 1'b1, 8'h12);
        ovr_en = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R3 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule